// File: doc/BRIEF.md
# Priority Interrupt Controller with Per-Line Sensitivity

This block gathers a parameter-set number of interrupt lines into one request to a processor. Each line is configured when the block is built as either edge-sensitive, where a 0-to-1 transition latches a status bit, or level-sensitive, where the status bit follows a high line and comes back after an acknowledge if the line is still high. Latched status is masked by a per-line enable to form the pending set. A fixed priority picks the pending line with the lowest index, and software reads that index from a vector register.

A two-bit master register does two jobs. One bit gates the request output. The other bit arms hardware capture, and once it is set it stays set until reset. Before that bit is set the physical lines are not captured, and software may write the status register to raise test interrupts. After it is set, software writes to status have no effect.

The register port is a plain single-cycle write strobe with address and data, plus a separate combinational read address. No bus protocol is implied.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, status, enable and master read 0, the vector register reads all ones and `irq_o` is low.
- R2: Register addresses are: 0 status (read/write), 1 pending (read), 2 enable (read/write), 3 acknowledge (write), 4 enable-set (write), 5 enable-clear (write), 6 vector (read), 7 master (read/write). Addresses 3, 4 and 5 read as 0.
- R3: A line whose `EDGE_MASK` bit is 1 sets its status bit at the first clock edge where it is sampled high after having been sampled low. A line held high does not set the bit again after it is acknowledged.
- R4: A line whose `EDGE_MASK` bit is 0 sets its status bit at every clock edge where it is sampled high. An acknowledge while the line is still high leaves the bit set.
- R5: Writing the acknowledge address clears each status bit whose data bit is 1 and leaves bits with data 0 unchanged. A capture in the same cycle wins over the clear.
- R6: Writing address 2 replaces the enables, address 4 sets the enable bits given by 1s in the data, and address 5 clears them. Pending reads as status AND enable.
- R7: The vector register returns the lowest index whose pending bit is set (bit 0 has the highest priority), zero-extended. It returns all ones when no bit is pending.
- R8: `irq_o` is high exactly when some pending bit is set and master bit 0 (request enable) is 1.
- R9: Master bit 1 (hardware enable) can be set but cannot be cleared by a write. While it is 0, lines are not captured and a write to status ORs the data into status. While it is 1, status writes are ignored.
- R10: `NUM_SRC` does not exceed `BUS_W` (8, 16 or 32). Status, pending and enable bits at index `NUM_SRC` and above read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines, bit 0 highest priority |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BUS_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | BUS_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Each write and each sampled line takes effect at the next rising edge. Reads and `irq_o` are combinational from the registers, so every result is due one edge after its stimulus. The bench applies the inputs just after a falling edge and advances its reference model to the next-state values for that edge. One falling edge later it points the read address at a register chosen at random or by a directed step, and compares. The same loop covers sticky arming, status writes in software mode, edge-versus-level capture around acknowledges, and priority among simultaneous lines.

// File: rtl/prio_irq_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes a 3-bit register address space with one register per address.
package prio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RS_STATUS = 3'd0,
        RS_PEND   = 3'd1,
        RS_ENABLE = 3'd2,
        RS_ACK    = 3'd3,
        RS_SETEN  = 3'd4,
        RS_CLREN  = 3'd5,
        RS_VECTOR = 3'd6,
        RS_MASTER = 3'd7
    } reg_sel_e;

    localparam int MST_IRQ_EN_BIT = 0;
    localparam int MST_HW_EN_BIT  = 1;

endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration registers: per-line enable and the two-bit master register.
// Also decodes the write strobes that other modules act on.
// Assumes writes are single-cycle pulses. The hardware-enable bit is sticky until reset.
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int NUM_SRC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    output logic [NUM_SRC-1:0]    enable,
    output logic                  irq_en,
    output logic                  hw_en,
    output logic                  ack_stb,
    output logic                  sts_stb
);

    logic [NUM_SRC-1:0] wbits;
    logic en_wr, set_wr, clr_wr, mst_wr;

    // Decode the write address into one strobe per register.
    always_comb begin
        wbits   = wr_data[NUM_SRC-1:0];
        en_wr   = wr_en && (wr_addr == RS_ENABLE);
        set_wr  = wr_en && (wr_addr == RS_SETEN);
        clr_wr  = wr_en && (wr_addr == RS_CLREN);
        mst_wr  = wr_en && (wr_addr == RS_MASTER);
        ack_stb = wr_en && (wr_addr == RS_ACK);
        sts_stb = wr_en && (wr_addr == RS_STATUS);
    end

    // Enable register: whole-word write, bit set and bit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (en_wr) begin
            enable <= wbits;
        end else if (set_wr) begin
            enable <= enable | wbits;
        end else if (clr_wr) begin
            enable <= enable & ~wbits;
        end
    end

    // Master register: request gate is free, hardware enable only arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            hw_en  <= 1'b0;
        end else if (mst_wr) begin
            irq_en <= wr_data[MST_IRQ_EN_BIT];
            hw_en  <= hw_en | wr_data[MST_HW_EN_BIT];
        end
    end

    AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hw_en |=> hw_en); // R9
    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((enable & $past(wbits)) == '0)); // R6

endmodule

// File: rtl/irq_src_capture.sv
// Captures interrupt lines into the status register. Each line is built as
// edge- or level-sensitive according to EDGE_MASK. Handles acknowledge clears
// and software status writes.
// Assumes src_i is already synchronous to clk.
module irq_src_capture #(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               hw_en,
    input  logic               ack_stb,
    input  logic               sts_stb,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] status
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] cap;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] sw_mask;

    // Per-line capture condition, chosen by the sensitivity parameter.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
        if (EDGE_MASK[i]) begin : g_edge
            assign cap[i] = hw_en & src_i[i] & ~src_q[i];
        end else begin : g_level
            assign cap[i] = hw_en & src_i[i];
        end
    end

    // Acknowledge and software-set masks for this cycle.
    always_comb begin
        clr_mask = ack_stb ? wbits : '0;
        sw_mask  = (sts_stb && !hw_en) ? wbits : '0;
    end

    // Previous line values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_i;
    end

    // Status update: clear by acknowledge, then set by capture or software.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | sw_mask | cap;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> ((status & $past(wbits) & ~$past(cap)) == '0)); // R5
    AST_SW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && sts_stb && cap == '0) |=> $stable(status)); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && (src_i & ~EDGE_MASK) != '0)
        |=> ((status & $past(src_i & ~EDGE_MASK)) == $past(src_i & ~EDGE_MASK))); // R4
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_en && !sts_stb) |=> ((status & ~$past(status)) == '0)); // R9

endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder: lowest set index wins.
// Assumes NUM_SRC >= 1. The valid flag is low when no bit is set.
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               valid
);

    // Scan from the top down so the lowest set bit is assigned last.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the priority interrupt controller: configuration registers, line
// capture, priority encoder, read mux and request output.
// Assumes NUM_SRC <= BUS_W and a bus width of 8, 16 or 32. Reads are combinational.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                 BUS_W     = 32,
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic [2:0]            rd_addr,
    output logic [BUS_W-1:0]      rd_data,
    output logic                  irq_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    initial begin
        AST_PARAM_OK: assert (NUM_SRC >= 1 && NUM_SRC <= BUS_W &&
            (BUS_W == 8 || BUS_W == 16 || BUS_W == 32)); // R10
    end

    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] pend;
    logic               irq_en, hw_en, ack_stb, sts_stb;
    logic [IDX_W-1:0]   vec_idx;
    logic               vec_valid;

    irq_cfg_regs #(.BUS_W(BUS_W), .NUM_SRC(NUM_SRC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .enable  (enable),
        .irq_en  (irq_en),
        .hw_en   (hw_en),
        .ack_stb (ack_stb),
        .sts_stb (sts_stb)
    );

    irq_src_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .hw_en   (hw_en),
        .ack_stb (ack_stb),
        .sts_stb (sts_stb),
        .wbits   (wr_data[NUM_SRC-1:0]),
        .status  (status)
    );

    // Pending lines are latched status masked by enable.
    always_comb pend = status & enable;

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .req   (pend),
        .idx   (vec_idx),
        .valid (vec_valid)
    );

    // Request output: any pending line, gated by the master request bit.
    always_comb irq_o = vec_valid & irq_en;

    // Read mux, zero-extending the per-line registers to the bus width.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            RS_STATUS: rd_data = BUS_W'(status);
            RS_PEND:   rd_data = BUS_W'(pend);
            RS_ENABLE: rd_data = BUS_W'(enable);
            RS_VECTOR: rd_data = vec_valid ? BUS_W'(vec_idx) : '1;
            RS_MASTER: rd_data = BUS_W'({hw_en, irq_en});
            default:   rd_data = '0;
        endcase
    end

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (pend[vec_idx] &&
        ((pend & ~({NUM_SRC{1'b1}} << vec_idx)) == '0))); // R7
    AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status & enable) != '0)); // R8
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable) == '0) |-> !vec_valid); // R7

endmodule

// File: tb/test_prio_irq_ctrl.sv
// Self-checking bench: directed corner cases followed by seeded random traffic,
// compared against a reference model kept in bench variables.
module test_prio_irq_ctrl;

    localparam int         BUS_W = 32;
    localparam int         N     = 8;
    localparam logic [7:0] EDGE  = 8'hA5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    src_i = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = '0;
    logic [BUS_W-1:0] wr_data = '0;
    logic [2:0]      rd_addr = '0;
    logic [BUS_W-1:0] rd_data;
    logic            irq_o;

    int n_vec = 0;
    int n_bad = 0;

    prio_irq_ctrl #(.BUS_W(BUS_W), .NUM_SRC(N), .EDGE_MASK(EDGE)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    // Reference model: current and next-edge state.
    logic [N-1:0] m_sts, m_en, m_srcq, n_sts, n_en, n_srcq;
    logic         m_ie, m_hw, n_ie, n_hw;

    function automatic logic [BUS_W-1:0] exp_read(input logic [2:0] a);
        logic [N-1:0] p;
        p = m_sts & m_en;
        case (a)
            3'd0: return BUS_W'(m_sts);
            3'd1: return BUS_W'(p);
            3'd2: return BUS_W'(m_en);
            3'd6: begin
                for (int i = 0; i < N; i++) if (p[i]) return BUS_W'(i);
                return '1;
            end
            3'd7: return BUS_W'({m_hw, m_ie});
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R3 R4 R5 R9 status";
            3'd1: return "R6 pending";
            3'd2: return "R6 enable";
            3'd6: return "R7 vector";
            3'd7: return "R9 master";
            default: return "R2 write-only read";
        endcase
    endfunction

    // Compute the state expected after the next edge from the driven inputs.
    task automatic model_next();
        logic [N-1:0] w, cap;
        w   = wr_data[N-1:0];
        cap = m_hw ? ((EDGE & src_i & ~m_srcq) | (~EDGE & src_i)) : '0;
        n_sts = m_sts; n_en = m_en; n_ie = m_ie; n_hw = m_hw; n_srcq = src_i;
        if (!rst_n) begin
            n_sts = '0; n_en = '0; n_ie = 1'b0; n_hw = 1'b0; n_srcq = '0;
        end else begin
            if (wr_en && wr_addr == 3'd3) n_sts = n_sts & ~w;
            if (wr_en && wr_addr == 3'd0 && !m_hw) n_sts = n_sts | w;
            n_sts = n_sts | cap;
            if (wr_en && wr_addr == 3'd2) n_en = w;
            if (wr_en && wr_addr == 3'd4) n_en = m_en | w;
            if (wr_en && wr_addr == 3'd5) n_en = m_en & ~w;
            if (wr_en && wr_addr == 3'd7) begin
                n_ie = wr_data[0];
                n_hw = m_hw | wr_data[1];
            end
        end
    endtask

    task automatic check(input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp,
                         input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check outputs from the last edge, then drive new inputs.
    task automatic cyc(input logic w, input logic [2:0] a, input logic [BUS_W-1:0] d,
                       input logic [N-1:0] s, input logic [2:0] ra);
        @(negedge clk);
        m_sts = n_sts; m_en = n_en; m_ie = n_ie; m_hw = n_hw; m_srcq = n_srcq;
        rd_addr = ra;
        #1;
        if (rst_n) begin
            check(rd_data, exp_read(ra), tag_of(ra));
            check(BUS_W'(irq_o), BUS_W'(((m_sts & m_en) != '0) && m_ie), "R8 irq_o");
            if (ra <= 3'd2)
                check(rd_data >> N, '0, "R10 upper bits");
        end
        wr_en = w; wr_addr = a; wr_data = d; src_i = s;
        model_next();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1'b0, 3'd0, '0, '0, 3'd0);
        rst_n = 1'b1;
        model_next();
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [N-1:0] s;
        void'($urandom(32'h5EED_0042));
        n_sts = '0; n_en = '0; n_ie = 0; n_hw = 0; n_srcq = '0;
        do_reset();
        // R1: reset values on every readable register.
        cyc(0, 0, '0, '0, 3'd0);
        check(rd_data, '0, "R1 status after reset");
        cyc(0, 0, '0, '0, 3'd6);
        check(rd_data, '1, "R1 vector after reset");
        check(BUS_W'(irq_o), '0, "R1 irq after reset");
        // R9: lines ignored before arming, status write raises test interrupts.
        cyc(0, 0, '0, 8'hFF, 3'd0);
        cyc(1, 3'd2, 32'hFF, 8'hFF, 3'd0);
        cyc(1, 3'd7, 32'h1, 8'h00, 3'd0);
        cyc(1, 3'd0, 32'hFFFF_FF28, 8'h00, 3'd0);
        cyc(0, 0, '0, '0, 3'd0);
        check(rd_data, 32'h28, "R9 R10 software status write");
        cyc(0, 0, '0, '0, 3'd6);
        check(rd_data, 32'd3, "R7 lowest pending index");
        // R5: ack with mixed ones and zeros.
        cyc(1, 3'd3, 32'h08, '0, 3'd6);
        cyc(0, 0, '0, '0, 3'd6);
        check(rd_data, 32'd5, "R5 ack cleared bit 3 only");
        // R6: enable-clear hides pending, request drops.
        cyc(1, 3'd5, 32'h20, '0, 3'd1);
        cyc(0, 0, '0, '0, 3'd1);
        check(rd_data, '0, "R6 cleared enable masks pending");
        check(BUS_W'(irq_o), '0, "R8 no request without pending");
        cyc(1, 3'd4, 32'h20, '0, 3'd1);
        cyc(1, 3'd7, 32'h0, '0, 3'd1);
        cyc(0, 0, '0, '0, 3'd1);
        check(BUS_W'(irq_o), '0, "R8 request gated by master bit 0");
        cyc(1, 3'd3, 32'hFF, '0, 3'd0);
        // Arm hardware; clearing attempt must not disarm.
        cyc(1, 3'd7, 32'h3, '0, 3'd0);
        cyc(1, 3'd7, 32'h1, '0, 3'd7);
        cyc(0, 0, '0, '0, 3'd7);
        check(rd_data, 32'h3, "R9 hardware enable sticky");
        cyc(1, 3'd0, 32'hFF, '0, 3'd0);
        cyc(0, 0, '0, '0, 3'd0);
        check(rd_data, '0, "R9 status write ignored once armed");
        // R3: edge line 0 held high, ack, no re-set.
        cyc(0, 0, '0, 8'h01, 3'd0);
        cyc(0, 0, '0, 8'h01, 3'd0);
        check(rd_data, 32'h01, "R3 edge captured");
        cyc(1, 3'd3, 32'h01, 8'h01, 3'd0);
        cyc(0, 0, '0, 8'h01, 3'd0);
        check(rd_data, '0, "R3 held edge line not re-set");
        // R4: level line 1 re-asserts after ack while high.
        cyc(0, 0, '0, 8'h02, 3'd0);
        cyc(1, 3'd3, 32'h02, 8'h02, 3'd0);
        cyc(0, 0, '0, 8'h00, 3'd0);
        check(rd_data, 32'h02, "R4 level line survives ack");
        cyc(1, 3'd3, 32'hFF, '0, 3'd0);
        // Random phase in software mode, then in hardware mode.
        for (int ph = 0; ph < 2; ph++) begin
            do_reset();
            if (ph == 1) cyc(1, 3'd7, 32'h3, '0, 3'd0);
            for (int k = 0; k < 3000; k++) begin
                logic [2:0] a;
                logic [BUS_W-1:0] d;
                a = 3'($urandom);
                d = $urandom;
                if (a == 3'd7 && ph == 0) d[1] = 1'b0;
                s = (k % 7 == 0) ? 8'($urandom) : src_i;
                cyc(($urandom % 3) == 0, a, d, s, 3'($urandom));
            end
        end
        cyc(0, 0, '0, '0, 3'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule